// File: doc/BRIEF.md
# Microcontroller Clock and Low-Power State Controller

This block drives the clock pin of an attached microcontroller and keeps track of the bridge's low-power states. It runs on an internal tick that is a fixed multiple of the 6 MHz reference (`TICKS_PER_REF`, default 2, giving a 12 MHz tick). A 2-bit rate code divides that tick down to 1.5, 2.0, 3.0 or 6.0 MHz. A static override or a stop request can hold the output at a fixed level instead. The block also stretches reset pulses for the microcontroller, raises a wake request while it is stopped, and asks for resume signalling on the bus.

Firmware writes a 7-bit control byte over the serial link. The byte sits in a holding register until the end of the transfer that carried it (`cfg_commit`), and only then does it reach the live state. The two stop bits are the only live bits that clear themselves. A wake input, bus activity, resume detection or a bus reset clears them. Suspend and force-resume change only when firmware writes them. Firmware is expected to set suspend after roughly 3 ms of bus silence and to time the resume period itself.

Control byte fields: bit 0 static, bit 1 force-resume, bit 2 suspend, bit 3 stop-clock, bit 4 stop-oscillator, bits 6:5 rate.

Top module: `susp_clk_ctl`

## Requirements
- R1: The rate field (bits 6:5) sets the high/low run lengths of `mclk_out` in ticks: 00 gives 4/4 (1.5 MHz), 01 gives 4/2 (2.0 MHz, 2:1 duty), 10 gives 2/2 (3.0 MHz) and 11 gives 1/1 (6.0 MHz). Code 00 is in force after reset.
- R2: With static (bit 0) set, `mclk_out` equals the stop-clock bit (bit 3). With static clear and stop-clock set, `mclk_out` is held at 0.
- R3: Committing a byte with stop-oscillator (bit 4) set drives `osc_en` low and also sets stop-clock, so `mclk_out` is held at 0.
- R4: Both stop bits clear on the clock edge after any of `wake_in`, `bus_active`, `resume_det` or `bus_reset` is high. The clear wins over a commit in the same cycle.
- R5: `wake_irq` is high only while `wake_in` is high and a stop bit is set.
- R6: A byte loaded by `cfg_wr` has no effect on any output until `cfg_commit` is pulsed.
- R7: `rst_out_n` is low while `rst_n` is low. After `rst_n` rises, it stays low for 249 more sampled cycles: 248 ticks (31 periods of 1.5 MHz) plus one release cycle.
- R8: A rising `bus_reset` drives `rst_out_n` low for exactly 248 cycles, however long `bus_reset` stays high.
- R9: `suspend_o` follows bit 2 of the last committed byte and is not changed by wake, activity, resume or bus reset.
- R10: `resume_req` follows bit 1 of the last committed byte for as long as it stays set.
- R11: A rate change takes effect only when a low phase ends. Every run seen during the change has the full length of either the old rate or the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal tick (TICKS_PER_REF times the 6 MHz reference) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load `cfg_data` into the holding register |
| cfg_data | input | 7 | Control byte |
| cfg_commit | input | 1 | End of the serial write; apply the held byte |
| bus_active | input | 1 | Bus activity seen |
| resume_det | input | 1 | Resume state decoded on the bus |
| bus_reset | input | 1 | Bus reset in progress |
| wake_in | input | 1 | External wake event |
| mclk_out | output | 1 | Clock to the microcontroller |
| rst_out_n | output | 1 | Stretched active-low reset to the microcontroller |
| wake_irq | output | 1 | Wake request while stopped |
| resume_req | output | 1 | Request to signal resume upstream |
| suspend_o | output | 1 | Bridge suspend state |
| osc_en | output | 1 | Oscillator run enable |

## Verification
Two functions can land on the same edge: a commit that sets a stop bit, and a wake event that clears it. The bench raises `cfg_commit` (with stop-clock held) and `wake_in` in the same cycle. It then checks that `wake_irq` stays low and that `mclk_out` keeps toggling, which shows the clear won. A second overlap is a rate commit that arrives during a high phase. For that case, every run length in the following window must equal the full length of either the old rate or the new rate.

// File: rtl/susp_clk_pkg.sv
package susp_clk_pkg;

  localparam int unsigned CFG_W        = 7;
  localparam int unsigned BIT_STATIC   = 0;
  localparam int unsigned BIT_FRESUME  = 1;
  localparam int unsigned BIT_SUSPEND  = 2;
  localparam int unsigned BIT_STOPCLK  = 3;
  localparam int unsigned BIT_STOPOSC  = 4;
  localparam int unsigned RATE_LSB     = 5;
  localparam int unsigned RST_PERIODS  = 31;  // slow-clock periods of reset
  localparam int unsigned SLOW_DIV     = 4;   // reference periods per slow period

  typedef struct packed {
    logic [1:0] rate;
    logic       static_en;
    logic       stop_clk;
    logic       stop_osc;
    logic       suspend;
    logic       fresume;
  } live_cfg_t;

  function automatic live_cfg_t decode_cfg(input logic [CFG_W-1:0] b);
    live_cfg_t c;
    c.rate      = b[RATE_LSB +: 2];
    c.static_en = b[BIT_STATIC];
    c.fresume   = b[BIT_FRESUME];
    c.suspend   = b[BIT_SUSPEND];
    c.stop_osc  = b[BIT_STOPOSC];
    c.stop_clk  = b[BIT_STOPCLK] | b[BIT_STOPOSC];
    return c;
  endfunction

endpackage

// File: rtl/susp_cfg_stage.sv
module susp_cfg_stage
  import susp_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_i,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             cfg_commit,
  input  logic             stop_clr,
  output live_cfg_t        live
);

  logic [CFG_W-1:0] hold_q, hold_d;
  live_cfg_t        live_q, live_d;

  always_comb begin
    hold_d = hold_q;
    if (cfg_wr) hold_d = cfg_data;
  end

  always_comb begin
    live_d = live_q;
    if (cfg_commit) live_d = decode_cfg(hold_q);
    if (stop_clr) begin
      live_d.stop_clk = 1'b0;
      live_d.stop_osc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hold_q <= '0;
      live_q <= '0;
    end else begin
      hold_q <= hold_d;
      live_q <= live_d;
    end
  end

  assign live = live_q;

  // R6 R9 R10: firmware-owned fields move only on a commit
  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_commit |=> $stable({live_q.rate, live_q.static_en, live_q.suspend, live_q.fresume}));

  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_i)
    stop_clr |=> !(live_q.stop_clk || live_q.stop_osc));

  assert_osc_implies_clk_R3: assert property (@(posedge clk) disable iff (!rst_i)
    live_q.stop_osc |-> live_q.stop_clk);

endmodule

// File: rtl/susp_clk_div.sv
module susp_clk_div #(
  parameter int unsigned TICKS_PER_REF = 2
) (
  input  logic       clk,
  input  logic       rst_i,
  input  logic [1:0] rate,
  input  logic       gate,
  output logic       q
);

  localparam int unsigned CW = $clog2(2 * TICKS_PER_REF);
  localparam logic [CW-1:0] TC_SLOW = CW'(2 * TICKS_PER_REF - 1);
  localparam logic [CW-1:0] TC_REF  = CW'(TICKS_PER_REF - 1);
  localparam logic [CW-1:0] TC_FAST = CW'(TICKS_PER_REF / 2 - 1);

  function automatic logic [CW-1:0] tc_high(input logic [1:0] r);
    case (r)
      2'd0, 2'd1: return TC_SLOW;
      2'd2:       return TC_REF;
      default:    return TC_FAST;
    endcase
  endfunction

  function automatic logic [CW-1:0] tc_low(input logic [1:0] r);
    case (r)
      2'd0:       return TC_SLOW;
      2'd1, 2'd2: return TC_REF;
      default:    return TC_FAST;
    endcase
  endfunction

  logic          q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    act_q, act_d;

  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (gate) begin
      q_d   = 1'b0;
      cnt_d = '0;
      act_d = rate;
    end else if (q_q) begin
      if (cnt_q == tc_high(act_q)) begin
        q_d   = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == tc_low(act_q)) begin
        q_d   = 1'b1;
        cnt_d = '0;
        act_d = rate;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign q = q_q;

  // R11: phase counter never runs past the length of the rate it serves
  assert_run_bound_R11: assert property (@(posedge clk) disable iff (!rst_i)
    q_q |-> (cnt_q <= tc_high(act_q)));

  assert_gate_low_R2: assert property (@(posedge clk) disable iff (!rst_i)
    gate |=> !q_q);

endmodule

// File: rtl/susp_rst_stretch.sv
module susp_rst_stretch #(
  parameter int unsigned RST_TICKS = 248
) (
  input  logic clk,
  input  logic rst_i,
  input  logic bus_reset,
  output logic rst_out_n
);

  localparam int unsigned RW = $clog2(RST_TICKS + 1);
  localparam logic [RW-1:0] LOAD = RW'(RST_TICKS);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          bus_q;

  always_comb begin
    cnt_d = cnt_q;
    if (bus_reset && !bus_q)  cnt_d = LOAD;
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q <= LOAD;
      bus_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bus_q <= bus_reset;
    end
  end

  assign rst_out_n = (cnt_q == '0);

  assert_bus_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_reset && !bus_q) |=> !rst_out_n);

endmodule

// File: rtl/susp_clk_ctl.sv
module susp_clk_ctl
  import susp_clk_pkg::*;
#(
  parameter int unsigned TICKS_PER_REF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             cfg_commit,
  input  logic             bus_active,
  input  logic             resume_det,
  input  logic             bus_reset,
  input  logic             wake_in,
  output logic             mclk_out,
  output logic             rst_out_n,
  output logic             wake_irq,
  output logic             resume_req,
  output logic             suspend_o,
  output logic             osc_en
);

  localparam int unsigned RST_TICKS = RST_PERIODS * SLOW_DIV * TICKS_PER_REF;

  logic [1:0] rst_sync;
  logic       rst_i;
  live_cfg_t  live;
  logic       stop_clr;
  logic       div_q;
  logic       div_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign stop_clr = wake_in | bus_active | resume_det | bus_reset;

  susp_cfg_stage u_cfg (
    .clk       (clk),
    .rst_i     (rst_i),
    .cfg_wr    (cfg_wr),
    .cfg_data  (cfg_data),
    .cfg_commit(cfg_commit),
    .stop_clr  (stop_clr),
    .live      (live)
  );

  assign div_gate = live.static_en | live.stop_clk;

  susp_clk_div #(.TICKS_PER_REF(TICKS_PER_REF)) u_div (
    .clk  (clk),
    .rst_i(rst_i),
    .rate (live.rate),
    .gate (div_gate),
    .q    (div_q)
  );

  susp_rst_stretch #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk      (clk),
    .rst_i    (rst_i),
    .bus_reset(bus_reset),
    .rst_out_n(rst_out_n)
  );

  always_comb begin
    if (live.static_en)     mclk_out = live.stop_clk;
    else if (live.stop_clk) mclk_out = 1'b0;
    else                    mclk_out = div_q;
  end

  assign wake_irq   = wake_in & live.stop_clk;
  assign resume_req = live.fresume;
  assign suspend_o  = live.suspend;
  assign osc_en     = ~live.stop_osc;

  // R5: a wake request clears its own cause, so it never lasts two cycles
  assert_wake_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_i)
    wake_irq |=> !wake_irq);

endmodule

// File: tb/test_susp_clk_ctl.sv
module test_susp_clk_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_commit, bus_active, resume_det, bus_reset, wake_in;
  logic [6:0] cfg_data;
  logic       mclk_out, rst_out_n, wake_irq, resume_req, suspend_o, osc_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  susp_clk_ctl i_susp_clk_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .cfg_commit(cfg_commit), .bus_active(bus_active), .resume_det(resume_det),
    .bus_reset(bus_reset), .wake_in(wake_in), .mclk_out(mclk_out),
    .rst_out_n(rst_out_n), .wake_irq(wake_irq), .resume_req(resume_req),
    .suspend_o(suspend_o), .osc_en(osc_en)
  );

  // {cfg byte, high run, low run, level}; high run 0 means a constant level
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 4'd4, 4'd4, 4'd0},  // R1 rate 00
    {8'h20, 4'd4, 4'd2, 4'd0},  // R1 rate 01
    {8'h40, 4'd2, 4'd2, 4'd0},  // R1 rate 10
    {8'h60, 4'd1, 4'd1, 4'd0},  // R1 rate 11
    {8'h01, 4'd0, 4'd0, 4'd0},  // R2 static, stop clear
    {8'h09, 4'd0, 4'd0, 4'd1},  // R2 static, stop set
    {8'h08, 4'd0, 4'd0, 4'd0},  // R2 stop only
    {8'h10, 4'd0, 4'd0, 4'd0},  // R3 stop oscillator
    {8'h41, 4'd0, 4'd0, 4'd0},  // R2 static over rate 10
    {8'h62, 4'd1, 4'd1, 4'd0},  // R10 force resume
    {8'h04, 4'd4, 4'd4, 4'd0},  // R9 suspend
    {8'h49, 4'd0, 4'd0, 4'd1},  // R2 static high over rate 10
    {8'h26, 4'd4, 4'd2, 4'd0}   // R9 R10 rate 01
  };

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_only(input logic [6:0] b);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = b;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic write_cfg(input logic [6:0] b);
    load_only(b);
    cfg_commit = 1'b1;
    @(negedge clk); cfg_commit = 1'b0;
  endtask

  task automatic run_lengths(output int hi, output int lo);
    logic prev;
    prev = mclk_out;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (!prev && mclk_out) break;
      prev = mclk_out;
    end
    hi = 1;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (!mclk_out) break; hi++; end
    lo = 1;
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (mclk_out) break; lo++; end
  endtask

  task automatic count_toggles(input int n, output int t);
    logic prev;
    prev = mclk_out; t = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk_out != prev) t++;
      prev = mclk_out;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hi, lo, t, lows, bad, runs, run;
    logic prev;
    rst_n = 1'b0; cfg_wr = 0; cfg_commit = 0; cfg_data = '0;
    bus_active = 0; resume_det = 0; bus_reset = 0; wake_in = 0;
    tick(5);
    // reset state
    check_eq("R7 rst_out_n in reset", rst_out_n, 0);
    check_eq("R1 mclk_out in reset", mclk_out, 0);
    check_eq("R5 wake_irq in reset", wake_irq, 0);
    check_eq("R10 resume_req in reset", resume_req, 0);
    check_eq("R9 suspend_o in reset", suspend_o, 0);
    check_eq("R3 osc_en in reset", osc_en, 1);
    rst_n = 1'b1;
    lows = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rst_out_n) break;
      lows++;
    end
    check_eq("R7 reset stretch after release", lows, 249);
    run_lengths(hi, lo);
    check_eq("R1 default high run", hi, 4);
    check_eq("R1 default low run", lo, 4);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] b;
      b = VEC[v][19:12];
      write_cfg(b[6:0]);
      tick(20);
      if (VEC[v][11:8] == 0) begin
        bad = 0;
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          if (mclk_out != VEC[v][0]) bad++;
        end
        check_eq("R2 R3 held level mismatches", bad, 0);
      end else begin
        run_lengths(hi, lo);
        check_eq("R1 high run", hi, int'(VEC[v][11:8]));
        check_eq("R1 low run", lo, int'(VEC[v][7:4]));
      end
      check_eq("R10 resume_req", resume_req, b[1]);
      check_eq("R9 suspend_o", suspend_o, b[2]);
      check_eq("R3 osc_en", osc_en, !b[4]);
    end

    // R6: held byte has no effect until commit
    write_cfg(7'h00);
    tick(20);
    load_only(7'h46);
    tick(20);
    run_lengths(hi, lo);
    check_eq("R6 high run before commit", hi, 4);
    check_eq("R6 low run before commit", lo, 4);
    check_eq("R6 suspend_o before commit", suspend_o, 0);
    check_eq("R6 resume_req before commit", resume_req, 0);
    @(negedge clk); cfg_commit = 1'b1; @(negedge clk); cfg_commit = 1'b0;
    tick(20);
    run_lengths(hi, lo);
    check_eq("R6 high run after commit", hi, 2);
    check_eq("R6 suspend_o after commit", suspend_o, 1);

    // R4 R5: wake clears stop, request only while stopped
    write_cfg(7'h00);
    wake_in = 1'b1; tick(2);
    check_eq("R5 wake_irq without stop", wake_irq, 0);
    wake_in = 1'b0;
    write_cfg(7'h0C);
    tick(5);
    check_eq("R5 wake_irq stopped, wake low", wake_irq, 0);
    wake_in = 1'b1; #1;
    check_eq("R5 wake_irq stopped, wake high", wake_irq, 1);
    @(negedge clk);
    check_eq("R4 wake clears stop", wake_irq, 0);
    wake_in = 1'b0;
    count_toggles(20, t);
    check_eq("R4 clock resumes after wake", t > 2, 1);
    check_eq("R9 suspend kept after wake", suspend_o, 1);

    // R4 R9: bus activity clears stop, not suspend
    write_cfg(7'h1C);
    tick(5);
    check_eq("R3 osc_en low when stopped", osc_en, 0);
    bus_active = 1'b1; @(negedge clk); bus_active = 1'b0;
    check_eq("R4 osc_en after activity", osc_en, 1);
    check_eq("R9 suspend kept after activity", suspend_o, 1);
    count_toggles(20, t);
    check_eq("R4 clock resumes after activity", t > 2, 1);

    // R4: resume detect clears stop
    write_cfg(7'h08);
    tick(5);
    resume_det = 1'b1; @(negedge clk); resume_det = 1'b0;
    count_toggles(20, t);
    check_eq("R4 clock resumes after resume detect", t > 2, 1);

    // R4: same-cycle commit and wake, clear wins
    load_only(7'h08);
    cfg_commit = 1'b1; wake_in = 1'b1;
    @(negedge clk);
    check_eq("R4 R5 wake_irq after same-cycle clash", wake_irq, 0);
    cfg_commit = 1'b0; wake_in = 1'b0;
    count_toggles(20, t);
    check_eq("R4 clock runs after same-cycle clash", t > 2, 1);

    // R11: rate change committed during a high phase
    write_cfg(7'h00);
    tick(20);
    load_only(7'h40);
    for (int i = 0; i < 64; i++) begin @(negedge clk); if (mclk_out) break; end
    cfg_commit = 1'b1; @(negedge clk); cfg_commit = 1'b0;
    prev = mclk_out; run = 0; bad = 0; runs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mclk_out != prev) begin
        if (runs > 0 && run != 2 && run != 4) bad++;
        runs++; run = 1;
      end else run++;
      prev = mclk_out;
    end
    check_eq("R11 runt runs during rate change", bad, 0);
    check_eq("R11 transitions seen", runs > 5, 1);

    // R8: long bus reset gives minimum-length pulse, clears stop
    write_cfg(7'h08);
    tick(3);
    bus_reset = 1'b1;
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!rst_out_n) lows++;
    end
    bus_reset = 1'b0;
    check_eq("R8 bus reset stretch length", lows, 248);
    count_toggles(20, t);
    check_eq("R4 clock resumes after bus reset", t > 2, 1);

    finish_run();
  end

endmodule